// File: doc/BRIEF.md
# Vector Register Pair Save/Restore Sequencer

This block moves one even/odd pair of vector registers between the vector register file and a save area in memory. It moves one 64-bit doubleword per step. Each doubleword carries one element of the even register in its upper 32 bits and the same element of the odd register in its lower 32 bits. The block has three modes:

- restore: memory to registers;
- save: registers to memory;
- save-only-if-changed: registers to memory, but only when the pair has changed.

Software passes two 32-bit control words:

- the save-area address;
- a word that holds the element number in bits 31:16 and the pair number in bits 15:0.

The block first checks both words for legal values. It then moves the remaining elements of the pair, one memory request at a time. After every acknowledged element it writes its progress back into the control words, so an interrupted sequence can be resumed from the words alone.

Some pairs are not moved. In restore and save modes these are pairs that are not in use. In save-only-if-changed mode these are pairs that have not changed. For such a pair the address is still advanced as if the pair had been moved. On completion the block does three things:

- it steps the pair number by two;
- it clears the element field;
- it reports a condition code that says whether the pair was moved and whether it was the last pair.

The block also pulses requests to set or clear the pair's changed bit. The surrounding logic owns the in-use and changed bits.

Top module: `vpair_xfer_seq`

## Requirements
- R1: A start is rejected with `done` and `spec_err` both high, no memory request and unchanged `addr_out`/`ctl_out` in any of these cases:
  - the element field (bits 31:16) is at least the section size (8);
  - the pair field (bits 15:0) has any bit under mask 0xFFF1 set;
  - `(addr - 8*element) mod 32` is nonzero, where 32 is the section size times the alignment factor 4.
- R2: Per element, a save drives `mem_wdata` = {even element, odd element} with `mem_we` high. A restore keeps `mem_we` low and, in the acknowledge cycle, writes `mem_rdata[63:32]` to the even register and `mem_rdata[31:0]` to the odd register, at the current element.
- R3: Every acknowledged element adds 8 to the address and 1 to the element field. While a request is stalled without `mem_ack`, `mem_addr` and `ctl_out` hold still.
- R4: A pair is skipped with no memory request when its `pair_in_use` bit is 0 (mode 0 restore, mode 1 save) or its `pair_changed` bit is 0 (mode 2 or 3, save-only-if-changed). A skipped pair still advances the address by 8 times (8 - starting element).
- R5: On a legal completion, `cc` = 2 if the pair was moved and 0 if it was skipped, plus 1 when the pair number is not 14. A rejected start leaves `cc` unchanged.
- R6: On a legal completion, `ctl_out` holds the pair number plus 2 in bits 15:0 and zero in bits 31:16.
- R7: The changed-bit requests pulse together with `done`, with `chg_idx` = pair number / 2:
  - `chg_clr` pulses after a save-only-if-changed that moved data;
  - `chg_set` pulses after a restore that moved data while `user_mode` was high at start;
  - neither pulses in any other case.
- R8: A `start` pulse while the block is busy is ignored: it has no effect on the address, element or data sequence in progress.
- R9: A nonzero starting element resumes the sequence. Only elements from the starting element up to 7 are moved, and `ctl_out[31:16]` shows the current element during each request.
- R10: After reset, `busy`, `done`, `mem_req`, `cc`, `addr_out` and `ctl_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pair transfer (taken only when idle) |
| mode | input | 2 | 0 restore, 1 save, 2/3 save-only-if-changed |
| user_mode | input | 1 | Requester is in user (problem) state |
| addr_in | input | 32 | Save-area address control word |
| ctl_in | input | 32 | Element number [31:16], pair number [15:0] |
| pair_in_use | input | NPAIR | In-use bit per pair |
| pair_changed | input | NPAIR | Changed bit per pair |
| busy | output | 1 | Element transfers in progress |
| done | output | 1 | One-cycle completion pulse |
| spec_err | output | 1 | Start was rejected (valid with done) |
| cc | output | 2 | Condition code of the last legal completion |
| addr_out | output | 32 | Live save-area address |
| ctl_out | output | 32 | Live element/pair control word |
| chg_set | output | 1 | Request to set the changed bit of chg_idx |
| chg_clr | output | 1 | Request to clear the changed bit of chg_idx |
| chg_idx | output | PIDX_W | Pair index for the changed-bit request |
| rf_idx | output | PIDX_W | Register-file pair index |
| rf_elem | output | EIDX_W | Register-file element index |
| rf_rd_even | input | EW | Even-register element read data |
| rf_rd_odd | input | EW | Odd-register element read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_even | output | EW | Even-register element write data |
| rf_wr_odd | output | EW | Odd-register element write data |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write (save) when high |
| mem_addr | output | 32 | Memory doubleword address |
| mem_wdata | output | 2*EW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, ends the current element |
| mem_rdata | input | 2*EW | Memory read data, valid with mem_ack |

## Verification
The bench targets the following corner cases:

- **Each of the three rejection rules on its own.** A design that dropped one would move data from a misaligned address or from an illegal pair.
- **Pair 14, moved and skipped.** A design with a wrong last-pair test would report 3 instead of 2, or 1 instead of 0.
- **Resumed starts at a nonzero element.** A design that restarted at element zero would overwrite save-area doublewords below the starting address.
- **Acknowledge stalls, with a stray start injected during a stall.** A design that advanced its control words early, or took the second start, would show a moving address during the stall or jump to the injected address.

Random operations also compare the changed-bit pulses and the skipped-pair address advance against the bench's own model.

// File: rtl/vps_pkg.sv
package vps_pkg;

  localparam logic [1:0] XM_RESTORE = 2'd0;
  localparam logic [1:0] XM_SAVE    = 2'd1;

  // Legality of a start: element range, pair field, save-area alignment.
  function automatic logic f_spec_bad(input logic [31:0] addr,
                                      input logic [31:0] ctl,
                                      input int          sect,
                                      input int          align_f,
                                      input logic [15:0] pmask);
    logic [31:0] el;
    logic [31:0] base;
    el   = {16'd0, ctl[31:16]};
    base = addr - (el << 3);
    return (el >= 32'(sect)) ||
           ((ctl[15:0] & pmask) != 16'd0) ||
           ((base & 32'(sect * align_f - 1)) != 32'd0);
  endfunction

  // Address advance for a pair that is not moved.
  function automatic logic [31:0] f_skip_adv(input logic [15:0] el,
                                             input int          sect);
    return (32'(sect) - {16'd0, el}) << 3;
  endfunction

  // Condition code: 2 when moved, 0 when skipped, +1 unless last pair.
  function automatic logic [1:0] f_cc(input logic        moved,
                                      input logic [15:0] pair,
                                      input logic [15:0] last);
    return {moved, pair != last};
  endfunction

endpackage

// File: rtl/vps_check.sv
module vps_check
  import vps_pkg::*;
#(
  parameter int SECT    = 8,
  parameter int ALIGN_F = 4,
  parameter int NPAIR   = 8,
  localparam int PIDX_W = $clog2(NPAIR)
) (
  input  logic [31:0]      addr_i,
  input  logic [31:0]      ctl_i,
  input  logic [1:0]       mode_i,
  input  logic [NPAIR-1:0] in_use_i,
  input  logic [NPAIR-1:0] changed_i,
  output logic             bad_o,
  output logic             active_o
);
  localparam logic [15:0] PMASK = ~(16'(2 * NPAIR - 1) & 16'hFFFE);

  logic [PIDX_W-1:0] pidx;

  assign pidx     = ctl_i[PIDX_W:1];
  assign bad_o    = f_spec_bad(addr_i, ctl_i, SECT, ALIGN_F, PMASK);
  assign active_o = mode_i[1] ? changed_i[pidx] : in_use_i[pidx];

endmodule

// File: rtl/vps_cc.sv
module vps_cc
  import vps_pkg::*;
#(
  parameter int NPAIR = 8
) (
  input  logic        moved_i,
  input  logic [15:0] pair_i,
  output logic [1:0]  cc_o
);
  localparam logic [15:0] LAST_PAIR = 16'(2 * NPAIR - 2);

  assign cc_o = f_cc(moved_i, pair_i, LAST_PAIR);

endmodule

// File: rtl/vpair_xfer_seq.sv
module vpair_xfer_seq
  import vps_pkg::*;
#(
  parameter int SECT    = 8,
  parameter int ALIGN_F = 4,
  parameter int NPAIR   = 8,
  parameter int EW      = 32,
  localparam int PIDX_W = $clog2(NPAIR),
  localparam int EIDX_W = $clog2(SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              user_mode,
  input  logic [31:0]       addr_in,
  input  logic [31:0]       ctl_in,
  input  logic [NPAIR-1:0]  pair_in_use,
  input  logic [NPAIR-1:0]  pair_changed,
  output logic              busy,
  output logic              done,
  output logic              spec_err,
  output logic [1:0]        cc,
  output logic [31:0]       addr_out,
  output logic [31:0]       ctl_out,
  output logic              chg_set,
  output logic              chg_clr,
  output logic [PIDX_W-1:0] chg_idx,
  output logic [PIDX_W-1:0] rf_idx,
  output logic [EIDX_W-1:0] rf_elem,
  input  logic [EW-1:0]     rf_rd_even,
  input  logic [EW-1:0]     rf_rd_odd,
  output logic              rf_we,
  output logic [EW-1:0]     rf_wr_even,
  output logic [EW-1:0]     rf_wr_odd,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [2*EW-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [2*EW-1:0]   mem_rdata
);
  localparam int          STEP      = (2 * EW) / 8;
  localparam logic [15:0] LAST_ELEM = 16'(SECT - 1);

  typedef enum logic {ST_IDLE, ST_XFER} st_e;

  st_e               state_q;
  logic [31:0]       addr_q, ctl_q;
  logic [1:0]        mode_q;
  logic              user_q, done_q, err_q, set_q, clr_q;
  logic [1:0]        cc_q;
  logic [PIDX_W-1:0] cidx_q;

  // Named events for the assertions.
  logic        accept, start_bad, start_active;
  logic        elem_done, last_elem, xfer_on;
  logic [1:0]  cc_w;
  logic [15:0] cc_pair;

  vps_check #(.SECT(SECT), .ALIGN_F(ALIGN_F), .NPAIR(NPAIR)) u_chk (
    .addr_i   (addr_in),
    .ctl_i    (ctl_in),
    .mode_i   (mode),
    .in_use_i (pair_in_use),
    .changed_i(pair_changed),
    .bad_o    (start_bad),
    .active_o (start_active)
  );

  assign xfer_on   = (state_q == ST_XFER);
  assign accept    = start && (state_q == ST_IDLE);
  assign elem_done = xfer_on && mem_ack;
  assign last_elem = elem_done && (ctl_q[31:16] == LAST_ELEM);
  assign cc_pair   = xfer_on ? ctl_q[15:0] : ctl_in[15:0];

  vps_cc #(.NPAIR(NPAIR)) u_cc (
    .moved_i(xfer_on),
    .pair_i (cc_pair),
    .cc_o   (cc_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ctl_q   <= '0;
      mode_q  <= '0;
      user_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      set_q   <= 1'b0;
      clr_q   <= 1'b0;
      cc_q    <= '0;
      cidx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q <= mode;
            user_q <= user_mode;
            if (start_bad) begin
              addr_q <= addr_in;
              ctl_q  <= ctl_in;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else if (!start_active) begin
              addr_q <= addr_in + f_skip_adv(ctl_in[31:16], SECT);
              ctl_q  <= {16'd0, ctl_in[15:0] + 16'd2};
              cc_q   <= cc_w;
              err_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              addr_q  <= addr_in;
              ctl_q   <= ctl_in;
              err_q   <= 1'b0;
              state_q <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (elem_done) begin
            addr_q <= addr_q + 32'(STEP);
            if (last_elem) begin
              ctl_q   <= {16'd0, ctl_q[15:0] + 16'd2};
              cc_q    <= cc_w;
              done_q  <= 1'b1;
              set_q   <= (mode_q == XM_RESTORE) && user_q;
              clr_q   <= mode_q[1];
              cidx_q  <= ctl_q[PIDX_W:1];
              state_q <= ST_IDLE;
            end else begin
              ctl_q[31:16] <= ctl_q[31:16] + 16'd1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = xfer_on;
  assign done       = done_q;
  assign spec_err   = err_q;
  assign cc         = cc_q;
  assign addr_out   = addr_q;
  assign ctl_out    = ctl_q;
  assign chg_set    = set_q;
  assign chg_clr    = clr_q;
  assign chg_idx    = cidx_q;
  assign rf_idx     = ctl_q[PIDX_W:1];
  assign rf_elem    = ctl_q[16 +: EIDX_W];
  assign mem_req    = xfer_on;
  assign mem_we     = xfer_on && (mode_q != XM_RESTORE);
  assign mem_addr   = addr_q;
  assign mem_wdata  = {rf_rd_even, rf_rd_odd};
  assign rf_we      = elem_done && (mode_q == XM_RESTORE);
  assign rf_wr_even = mem_rdata[2*EW-1:EW];
  assign rf_wr_odd  = mem_rdata[EW-1:0];

  // ---------------- assertions ----------------
  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && spec_err) |-> (!mem_req && !chg_set && !chg_clr));

  assert_rf_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_ack && mem_req && !mem_we));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(ctl_out)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (addr_out == $past(addr_out) + 32'(STEP)));

  assert_cc_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !spec_err) |-> (cc[0] == (ctl_out[15:0] != 16'(2 * NPAIR))));

  assert_fin_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !spec_err) |-> (ctl_out[31:16] == 16'd0 && !ctl_out[0]));

  assert_chg_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_set || chg_clr) |-> (done && !spec_err && !(chg_set && chg_clr)));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ack) |=> (busy && $stable(mem_we) && $stable(addr_out)));

endmodule

// File: tb/sim_vpair_xfer_seq.sv
module sim_vpair_xfer_seq;
  localparam int SECT = 8;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, user_mode = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] addr_in = '0, ctl_in = '0;
  logic [7:0]  inuse = '0, chgd = '0;
  logic        busy, done, spec_err, chg_set, chg_clr, rf_we, mem_req, mem_we;
  logic [1:0]  cc;
  logic [31:0] addr_out, ctl_out, mem_addr, rf_rd_even, rf_rd_odd, rf_wr_even, rf_wr_odd;
  logic [2:0]  chg_idx, rf_idx, rf_elem;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic [31:0] rfe [8][8];
  logic [31:0] rfo [8][8];
  logic [63:0] smem [256];

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  assign rf_rd_even = rfe[rf_idx][rf_elem];
  assign rf_rd_odd  = rfo[rf_idx][rf_elem];

  vpair_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .user_mode(user_mode),
    .addr_in(addr_in), .ctl_in(ctl_in), .pair_in_use(inuse), .pair_changed(chgd),
    .busy(busy), .done(done), .spec_err(spec_err), .cc(cc),
    .addr_out(addr_out), .ctl_out(ctl_out), .chg_set(chg_set), .chg_clr(chg_clr),
    .chg_idx(chg_idx), .rf_idx(rf_idx), .rf_elem(rf_elem),
    .rf_rd_even(rf_rd_even), .rf_rd_odd(rf_rd_odd), .rf_we(rf_we),
    .rf_wr_even(rf_wr_even), .rf_wr_odd(rf_wr_odd), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [31:0] a, input logic [31:0] c);
    int unsigned el;
    el = c[31:16];
    if (el >= SECT) return 1'b1;
    if ((c[15:0] & 16'hFFF1) != 0) return 1'b1;
    return ((a - el * 8) % 32) != 0;
  endfunction

  task automatic run_op(input logic [1:0] md, input logic [31:0] a,
                        input logic [31:0] c, input bit usr, input bit poke);
    logic [15:0] el, pr;
    logic [2:0]  pi;
    logic [31:0] ea;
    logic [1:0]  ccx;
    int          ecur, steps, moved;
    bit          bad, act, saw;
    el = c[31:16]; pr = c[15:0]; pi = pr[3:1];
    bad = exp_bad(a, c);
    act = !bad && (md[1] ? chgd[pi] : inuse[pi]);
    ea = a; ecur = el; steps = 0; moved = 0; saw = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = md; addr_in = a; ctl_in = c; user_mode = usr;
    @(negedge clk);
    start = 1'b0;
    while (!done && steps < 200) begin
      if (mem_req) begin
        int          stall;
        logic [31:0] ma, co;
        saw = 1'b1;
        stall = poke ? 2 : int'($urandom % 3);
        for (int s = 0; s < stall; s++) begin
          ma = mem_addr; co = ctl_out;
          if (poke && s == 0) begin
            start = 1'b1; addr_in = 32'h0000_0700; ctl_in = 32'd6; mode = 2'd0;
          end
          @(negedge clk);
          start = 1'b0;
          chk(mem_addr == ma && ctl_out == co && mem_req, "R3 stall hold / R8 start ignored",
              {mem_addr, ctl_out}, {ma, co});
        end
        chk(mem_addr == ea, "R3 address", mem_addr, ea);
        chk(ctl_out[31:16] == 16'(ecur) && ctl_out[15:0] == pr, "R9 element field",
            ctl_out, {16'(ecur), pr});
        if (md != 2'd0) begin
          logic [63:0] wexp;
          wexp = {rfe[pi][ecur], rfo[pi][ecur]};
          chk(mem_we && mem_wdata == wexp, "R2 save data", mem_wdata, wexp);
          smem[ea[10:3]] = wexp;
          mem_ack = 1'b1;
        end else begin
          mem_rdata = smem[ea[10:3]];
          mem_ack = 1'b1;
          #1;
          chk(!mem_we && rf_we && rf_idx == pi && rf_elem == 3'(ecur) &&
              {rf_wr_even, rf_wr_odd} == mem_rdata, "R2 restore write",
              {rf_wr_even, rf_wr_odd}, mem_rdata);
          rfe[pi][ecur] = mem_rdata[63:32];
          rfo[pi][ecur] = mem_rdata[31:0];
        end
        @(negedge clk);
        mem_ack = 1'b0;
        ea = ea + 8; ecur++; moved++;
      end else begin
        @(negedge clk);
      end
      steps++;
    end
    chk(done == 1'b1, "R1/R4/R6 done pulse", done, 1);
    if (bad) begin
      chk(spec_err && !saw && addr_out == a && ctl_out == c, "R1 rejected start",
          {addr_out, ctl_out}, {a, c});
    end else begin
      ccx = {act, pr != 16'd14};
      chk(!spec_err, "R1 legal start", spec_err, 0);
      chk(addr_out == a + (SECT - el) * 8, act ? "R3 final address" : "R4 skip advance",
          addr_out, a + (SECT - el) * 8);
      chk(ctl_out == {16'd0, pr + 16'd2}, "R6 completion control", ctl_out, {16'd0, pr + 16'd2});
      chk(cc == ccx, "R5 condition code", cc, ccx);
      chk(saw == act && moved == (act ? SECT - el : 0), "R4/R9 element count", moved,
          act ? SECT - el : 0);
      chk(chg_set == (act && md == 2'd0 && usr) && chg_clr == (act && md[1]) &&
          (!(chg_set || chg_clr) || chg_idx == pi), "R7 changed-bit request",
          {chg_set, chg_clr, chg_idx}, {act && md == 2'd0 && usr, act && md[1], pi});
      if (chg_set) chgd[pi] = 1'b1;
      if (chg_clr) chgd[pi] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < 8; p++)
      for (int e = 0; e < 8; e++) begin
        rfe[p][e] = $urandom; rfo[p][e] = $urandom;
      end
    for (int i = 0; i < 256; i++) smem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && cc == 2'd0 && addr_out == 0 && ctl_out == 0,
        "R10 reset state", {busy, done, mem_req, cc}, 0);

    // Directed corner cases.
    inuse = 8'hFF; chgd = 8'h00;
    run_op(2'd1, 32'h0000_0040, 32'h0000_000E, 1'b0, 1'b0); // pair 14 moved: cc 2
    run_op(2'd0, 32'h0000_0080, 32'h0000_000E, 1'b1, 1'b0); // restore user: set
    run_op(2'd2, 32'h0000_00C0, 32'h0000_000E, 1'b0, 1'b0); // changed now: clear
    run_op(2'd2, 32'h0000_00C0, 32'h0000_000E, 1'b0, 1'b0); // unchanged: skip cc 0
    inuse = 8'hFE;
    run_op(2'd0, 32'h0000_0100, 32'h0000_0000, 1'b1, 1'b0); // pair 0 skip: cc 1
    run_op(2'd0, 32'h0000_0100, 32'h0000_0002, 1'b0, 1'b0); // restore supervisor
    run_op(2'd1, 32'h0000_0168, 32'h0005_0004, 1'b0, 1'b0); // resume at 5
    run_op(2'd1, 32'h0000_0200, 32'h0000_0006, 1'b0, 1'b1); // start poked while busy
    run_op(2'd1, 32'h0000_0200, 32'h0000_0003, 1'b0, 1'b0); // odd pair
    run_op(2'd1, 32'h0000_0200, 32'h0000_0010, 1'b0, 1'b0); // pair 16
    run_op(2'd1, 32'h0000_0240, 32'h0008_0002, 1'b0, 1'b0); // element 8
    run_op(2'd0, 32'h0000_0044, 32'h0000_0004, 1'b0, 1'b0); // misaligned

    // Constrained random operations.
    for (int k = 0; k < 60; k++) begin
      logic [15:0] pr, el;
      logic [31:0] a;
      inuse = 8'($urandom); chgd = 8'($urandom);
      pr = (($urandom % 8) == 0) ? 16'($urandom % 18) : 16'(($urandom % 8) * 2);
      el = (($urandom % 10) == 0) ? 16'd8 : 16'($urandom % 8);
      a  = ($urandom % 6) * 64 + 32'(el) * 8 + ((($urandom % 12) == 0) ? 32'd8 : 32'd0);
      run_op(2'($urandom % 3), a, {el, pr}, 1'($urandom), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule